// File: doc/BRIEF.md
# Serial EEPROM Write Sequencer

This controller sits on the host side of a three-wire serial EEPROM link and carries out a single word write. When the user side strobes `start`, it latches the address, the data word and the word-size select. It then shifts a write frame out on the serial data line and ends the transfer so that the memory starts its self-timed programming cycle. No fixed delay is used for completion. The controller keeps chip select low for a programmable minimum time, raises it again, and watches the memory's data-out line until it reports ready. It then clears that status indication with a lone start bit followed by chip select low, and raises `done` for one clock.

A parameter selects the programming trigger. In one setting the frame is closed by dropping chip select after the last clock. In the other, the rising clock edge of the last data bit is the trigger, and chip select falls together with that bit's clock. The serial clock is a divided version of the system clock. The data-out line is passed through a two-flop synchronizer. If ready is not seen within a bounded polling window, the controller flags a timeout and returns to idle.

Top module: `uwire_wr_seq`

## Requirements
- R1: A frame is the bit sequence 1, 0, 1 (start bit, then write opcode 01), the address most significant bit first, then the data most significant bit first. With `org16` low it uses `addr[ADDR_W8-1:0]` and `wdata[7:0]`, which is 3+7+8 = 18 clocks at default widths. With `org16` high it uses `addr[ADDR_W16-1:0]` and all of `wdata`, which is 3+6+16 = 25 clocks. Bits outside these fields have no effect.
- R2: `ee_di` changes only while `ee_sk` is low. `ee_sk` is low whenever chip select is low, and both are low while the controller is idle.
- R3: With `TRIG_ON_CLK` = 0, `ee_sk` has already been low for a half period when chip select falls after the last data bit. With `TRIG_ON_CLK` = 1, chip select falls in the same cycle as the falling clock of the last data bit.
- R4: After the frame, chip select stays low for exactly `CSL_CYC` system clocks before it is raised to poll status.
- R5: `ee_do` is never taken as ready while chip select is low, during the frame, or in the first `SETTLE` cycles of polling. A low level while polling means busy, and a synchronized high level means ready.
- R6: After ready is seen, the controller sends one serial clock pulse with `ee_di` = 1 and chip select high, then drops chip select. `done` pulses for exactly one cycle as this ends, and only once per write.
- R7: If ready is not seen within `POLL_MAX` polling cycles, `tmo_err` goes high, chip select goes low, `busy` falls and no `done` is given. `tmo_err` stays set until the next accepted start clears it.
- R8: A `start` while `busy` is high is ignored. The frame in progress is unchanged and no extra write occurs.
- R9: After reset, `busy`, `done`, `tmo_err`, `ee_cs`, `ee_sk` and `ee_di` are all low.
- R10: `busy` is high from the cycle after an accepted `start` until the write finishes or times out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one write; sampled while idle |
| addr | input | ADDR_W8 | Word address; low ADDR_W16 bits used in 16-bit mode |
| wdata | input | 16 | Data word; low 8 bits used in 8-bit mode |
| org16 | input | 1 | Word size select: 1 = 16-bit, 0 = 8-bit |
| busy | output | 1 | Write in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| tmo_err | output | 1 | Sticky polling timeout flag |
| ee_cs | output | 1 | Chip select to the memory |
| ee_sk | output | 1 | Serial clock to the memory |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data / ready-busy from the memory |

## Verification
The bench builds two copies with a half period of 2 system clocks, `CSL_CYC` = 8, `SETTLE` = 3 and `POLL_MAX` = 200. One copy uses each trigger variant. These small values keep a full write, the chip-select-low interval and a complete polling timeout within a few hundred cycles. Busy times are chosen to fall below, near and beyond the polling window. The memory model drives data-out high whenever chip select is low. A stale ready level would therefore reach the synchronizer just as polling begins, and the settle window has to reject it.

// File: rtl/uwire_wr_seq.sv
module uwire_wr_seq #(
  parameter int ADDR_W8     = 7,
  parameter int ADDR_W16    = 6,
  parameter int HALF_DIV    = 4,
  parameter int CSL_CYC     = 63,
  parameter int SETTLE      = 3,
  parameter int POLL_MAX    = 2000000,
  parameter bit TRIG_ON_CLK = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W8-1:0] addr,
  input  logic [15:0]        wdata,
  input  logic               org16,
  output logic               busy,
  output logic               done,
  output logic               tmo_err,
  output logic               ee_cs,
  output logic               ee_sk,
  output logic               ee_di,
  input  logic               ee_do
);

  localparam int L8   = 3 + ADDR_W8 + 8;
  localparam int L16  = 3 + ADDR_W16 + 16;
  localparam int FW   = (L8 > L16) ? L8 : L16;
  localparam int CW   = $clog2(FW + 1);
  localparam int DW   = $clog2(HALF_DIV + 1);
  localparam int WMAX = (CSL_CYC > POLL_MAX) ? CSL_CYC : POLL_MAX;
  localparam int WW   = $clog2(WMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_HOLD, S_CSL, S_POLL, S_CLR} st_t;

  st_t           st;
  logic [FW-1:0] sr;
  logic [CW-1:0] bits;
  logic [DW-1:0] div;
  logic [WW-1:0] wcnt;
  logic [1:0]    ph;
  logic          ds1, ds2;
  logic [FW-1:0] fr8, fr16;
  logic          tick;

  assign fr16 = FW'({3'b101, addr[ADDR_W16-1:0], wdata}) << (FW - L16);
  assign fr8  = FW'({3'b101, addr[ADDR_W8-1:0], wdata[7:0]}) << (FW - L8);
  assign tick = (div == DW'(HALF_DIV - 1));
  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ds1 <= 1'b0;
      ds2 <= 1'b0;
    end else begin
      ds1 <= ee_do;
      ds2 <= ds1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sr      <= '0;
      bits    <= '0;
      div     <= '0;
      wcnt    <= '0;
      ph      <= '0;
      ee_cs   <= 1'b0;
      ee_sk   <= 1'b0;
      ee_di   <= 1'b0;
      done    <= 1'b0;
      tmo_err <= 1'b0;
    end else begin
      done <= 1'b0;
      div  <= (tick || st == S_IDLE) ? '0 : div + 1'b1;
      case (st)
        S_IDLE: begin
          ee_cs <= 1'b0;
          ee_sk <= 1'b0;
          ee_di <= 1'b0;
          if (start) begin
            tmo_err <= 1'b0;
            sr      <= org16 ? (fr16 << 1) : (fr8 << 1);
            bits    <= org16 ? CW'(L16) : CW'(L8);
            ee_di   <= 1'b1;
            ee_cs   <= 1'b1;
            st      <= S_SHIFT;
          end
        end
        S_SHIFT: if (tick) begin
          if (!ee_sk) begin
            ee_sk <= 1'b1;
          end else begin
            ee_sk <= 1'b0;
            if (bits == CW'(1)) begin
              ee_di <= 1'b0;
              if (TRIG_ON_CLK) begin
                ee_cs <= 1'b0;
                wcnt  <= '0;
                st    <= S_CSL;
              end else begin
                st <= S_HOLD;
              end
            end else begin
              ee_di <= sr[FW-1];
              sr    <= sr << 1;
              bits  <= bits - 1'b1;
            end
          end
        end
        S_HOLD: if (tick) begin
          ee_cs <= 1'b0;
          wcnt  <= '0;
          st    <= S_CSL;
        end
        S_CSL: begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == WW'(CSL_CYC - 1)) begin
            ee_cs <= 1'b1;
            wcnt  <= '0;
            st    <= S_POLL;
          end
        end
        S_POLL: begin
          wcnt <= wcnt + 1'b1;
          if (wcnt >= WW'(SETTLE) && ds2) begin
            ee_di <= 1'b1;
            ph    <= '0;
            st    <= S_CLR;
          end else if (wcnt == WW'(POLL_MAX - 1)) begin
            tmo_err <= 1'b1;
            ee_cs   <= 1'b0;
            st      <= S_IDLE;
          end
        end
        S_CLR: if (tick) begin
          ph <= ph + 1'b1;
          case (ph)
            2'd0:    ee_sk <= 1'b1;
            2'd1:    ee_sk <= 1'b0;
            default: begin
              ee_cs <= 1'b0;
              ee_di <= 1'b0;
              done  <= 1'b1;
              st    <= S_IDLE;
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uwire_wr_seq_chk.sv
module uwire_wr_seq_chk #(
  parameter int CSL_CYC = 63
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic tmo_err,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di
);

  int low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= 0;
    else if (ee_cs) low_cnt <= 0;
    else if (low_cnt < CSL_CYC + 4) low_cnt <= low_cnt + 1;
  end

  a_r2_di_stable_sk_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

  a_r2_sk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);

  a_r2_idle_lines_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ee_cs && !ee_sk));

  a_r4_cs_low_interval: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ee_cs) && $past(busy)) |-> (low_cnt >= CSL_CYC));

  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r7_no_done_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tmo_err);

endmodule

bind uwire_wr_seq uwire_wr_seq_chk #(.CSL_CYC(CSL_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .tmo_err(tmo_err),
  .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
);

// File: tb/uwire_wr_seq_test.sv
`timescale 1ns/1ps

module ee_model (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        cs,
  input  logic        sk,
  input  logic        di,
  input  logic [15:0] busy_len,
  output logic        do_o,
  output logic [31:0] frame,
  output int          flen,
  output int          clears,
  output int          low_len,
  output logic        fall_sk,
  output int          early
);
  logic cs_q, sk_q, show, prog, timing;
  logic [31:0] cap;
  int n, bc, lc;

  assign do_o = (cs && show) ? !prog : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 0; sk_q <= 0; show <= 0; prog <= 0; timing <= 0; cap <= 0;
      n <= 0; bc <= 0; lc <= 0; frame <= 0; flen <= 0; clears <= 0;
      low_len <= 0; fall_sk <= 0; early <= 0;
    end else begin
      cs_q <= cs;
      sk_q <= sk;
      if (prog && busy_len != 16'hFFFF) begin
        if (bc <= 1) prog <= 1'b0;
        bc <= bc - 1;
      end
      if (timing && !cs) lc <= lc + 1;
      if (timing && cs) begin
        low_len <= lc;
        timing  <= 1'b0;
      end
      if (cs && sk && !sk_q) begin
        if (show) begin
          if (di) begin
            if (prog) early <= early + 1;
            show   <= 1'b0;
            clears <= clears + 1;
          end
        end else begin
          cap <= {cap[30:0], di};
          n   <= n + 1;
        end
      end
      if (!cs && cs_q && n > 0) begin
        frame   <= cap;
        flen    <= n;
        n       <= 0;
        cap     <= 0;
        prog    <= 1'b1;
        show    <= 1'b1;
        bc      <= int'(busy_len);
        fall_sk <= sk_q;
        timing  <= 1'b1;
        lc      <= 1;
      end
      if (clr) begin
        show <= 1'b0;
        prog <= 1'b0;
      end
    end
  end
endmodule

module uwire_wr_seq_test;
  localparam int HD  = 2;
  localparam int CSL = 8;
  localparam int ST  = 3;
  localparam int PM  = 200;
  localparam int NV  = 6;
  localparam logic [39:0] VEC [NV] = '{
    {1'b0, 7'h55, 16'h00A5, 16'd0},
    {1'b1, 7'h3F, 16'hBEEF, 16'd30},
    {1'b0, 7'h7F, 16'h1234, 16'd150},
    {1'b1, 7'h41, 16'h8001, 16'd5},
    {1'b0, 7'h00, 16'h0000, 16'd12},
    {1'b1, 7'h00, 16'hFFFF, 16'd60}
  };

  logic clk = 0, rst_n = 0;
  logic start = 0, start_k = 0, org16 = 0, mclr = 0;
  logic [6:0] addr = 0;
  logic [15:0] wdata = 0, blen = 0;
  logic busy, done, tmo_err, ee_cs, ee_sk, ee_di, ee_do;
  logic busy_k, done_k, err_k, cs_k, sk_k, di_k, do_k;
  logic [31:0] fr, fr_k;
  int fl, fl_k, clr_n, clr_k, low, low_k, early, early_k;
  logic fsk, fsk_k;
  int tests = 0, fails = 0, done_n = 0, done_kn = 0, viol = 0;
  logic sk_p = 0, di_p = 0;

  always #2 clk = ~clk;

  uwire_wr_seq #(.HALF_DIV(HD), .CSL_CYC(CSL), .SETTLE(ST), .POLL_MAX(PM), .TRIG_ON_CLK(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .wdata(wdata), .org16(org16),
    .busy(busy), .done(done), .tmo_err(tmo_err), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do));
  ee_model m0 (.clk(clk), .rst_n(rst_n), .clr(mclr), .cs(ee_cs), .sk(ee_sk), .di(ee_di), .busy_len(blen),
    .do_o(ee_do), .frame(fr), .flen(fl), .clears(clr_n), .low_len(low), .fall_sk(fsk), .early(early));

  uwire_wr_seq #(.HALF_DIV(HD), .CSL_CYC(CSL), .SETTLE(ST), .POLL_MAX(PM), .TRIG_ON_CLK(1'b1)) u_clk (
    .clk(clk), .rst_n(rst_n), .start(start_k), .addr(addr), .wdata(wdata), .org16(org16),
    .busy(busy_k), .done(done_k), .tmo_err(err_k), .ee_cs(cs_k), .ee_sk(sk_k), .ee_di(di_k), .ee_do(do_k));
  ee_model m1 (.clk(clk), .rst_n(rst_n), .clr(mclr), .cs(cs_k), .sk(sk_k), .di(di_k), .busy_len(blen),
    .do_o(do_k), .frame(fr_k), .flen(fl_k), .clears(clr_k), .low_len(low_k), .fall_sk(fsk_k), .early(early_k));

  always @(posedge clk) begin
    if (done) done_n++;
    if (done_k) done_kn++;
  end

  always @(negedge clk) begin
    if (rst_n && ee_sk && sk_p && ee_di != di_p) viol++;
    if (rst_n && !ee_cs && ee_sk) viol++;
    if (rst_n && !busy && (ee_cs || ee_sk)) viol++;
    sk_p = ee_sk;
    di_p = ee_di;
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_frame(input logic o, input logic [6:0] a, input logic [15:0] d);
    return o ? {7'b0, 3'b101, a[5:0], d} : {14'b0, 3'b101, a, d[7:0]};
  endfunction

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int d0, c0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk({busy, done, tmo_err, ee_cs, ee_sk, ee_di} == 6'b0, "R9", "outputs in reset",
        {busy, done, tmo_err, ee_cs, ee_sk, ee_di}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk({busy, done, tmo_err, ee_cs, ee_sk, ee_di} == 6'b0, "R9", "outputs after reset",
        {busy, done, tmo_err, ee_cs, ee_sk, ee_di}, 0);

    for (int v = 0; v < NV; v++) begin
      {org16, addr, wdata, blen} = VEC[v];
      d0 = done_n; c0 = clr_n;
      pulse_start();
      chk(busy == 1, "R10", "busy after accepted start", busy, 1);
      wait_idle();
      @(negedge clk);
      // R1 frame content and length
      chk(fr == exp_frame(org16, addr, wdata), "R1", "frame bits", fr, exp_frame(org16, addr, wdata));
      chk(fl == (org16 ? 25 : 18), "R1", "frame length", fl, org16 ? 25 : 18);
      chk(low == CSL, "R4", "cs low interval", low, CSL);
      chk(fsk == 0, "R3", "sk low at cs fall (cs mode)", fsk, 0);
      chk(done_n - d0 == 1, "R6", "single done pulse", done_n - d0, 1);
      chk(clr_n - c0 == 1, "R6", "status cleared once", clr_n - c0, 1);
      chk(early == 0, "R5", "no ready taken while busy", early, 0);
      chk(!tmo_err && !ee_cs, "R7", "no error, cs low", {tmo_err, ee_cs}, 0);
    end

    // R8 start ignored while busy
    org16 = 1; addr = 7'h15; wdata = 16'hC3A5; blen = 16'd40;
    d0 = done_n;
    pulse_start();
    repeat (20) @(negedge clk);
    addr = 7'h2A; wdata = 16'h0F0F; org16 = 0;
    pulse_start();
    repeat (60) @(negedge clk);
    pulse_start();
    wait_idle();
    repeat (4) @(negedge clk);
    chk(fr == exp_frame(1'b1, 7'h15, 16'hC3A5), "R8", "frame unchanged by start while busy",
        fr, exp_frame(1'b1, 7'h15, 16'hC3A5));
    chk(done_n - d0 == 1 && !busy, "R8", "one write only", done_n - d0, 1);

    // R7 timeout
    org16 = 0; addr = 7'h11; wdata = 16'h0077; blen = 16'hFFFF;
    d0 = done_n;
    pulse_start();
    wait_idle();
    @(negedge clk);
    chk(tmo_err == 1, "R7", "timeout flag", tmo_err, 1);
    chk(!ee_cs && !busy, "R7", "cs low and idle after timeout", {ee_cs, busy}, 0);
    chk(done_n == d0, "R7", "no done on timeout", done_n - d0, 0);
    repeat (5) @(negedge clk);
    chk(tmo_err == 1, "R7", "flag sticky while idle", tmo_err, 1);
    mclr = 1; @(negedge clk); mclr = 0;
    blen = 16'd10;
    pulse_start();
    chk(tmo_err == 0, "R7", "flag cleared by next start", tmo_err, 0);
    wait_idle();
    @(negedge clk);
    chk(done_n - d0 == 1 && fr == exp_frame(1'b0, 7'h11, 16'h0077), "R7", "write after timeout",
        fr, exp_frame(1'b0, 7'h11, 16'h0077));

    // R3 clock-trigger variant
    org16 = 1; addr = 7'h2D; wdata = 16'h5A3C; blen = 16'd20;
    d0 = done_kn;
    @(negedge clk) start_k = 1;
    @(negedge clk) start_k = 0;
    for (int i = 0; i < 4000 && busy_k; i++) @(negedge clk);
    @(negedge clk);
    chk(fsk_k == 1, "R3", "cs falls with last sk (clock mode)", fsk_k, 1);
    chk(fr_k == exp_frame(1'b1, 7'h2D, 16'h5A3C), "R3", "clock mode frame", fr_k, exp_frame(1'b1, 7'h2D, 16'h5A3C));
    chk(low_k == CSL && done_kn - d0 == 1 && clr_k == 1, "R3", "clock mode completion", low_k, CSL);

    // R2 line discipline over whole run
    chk(viol == 0, "R2", "di/sk/cs ordering violations", viol, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule